// File: doc/BRIEF.md
# DSP Load Address Generator

This block turns one load request into the address driven to memory and, where the mode asks for it, the updated value of the pointer register. A request carries a 3-bit mode code, a 2-bit access-size code, a base pointer (also used as the index operand), a signed immediate, a modifier word, a circular-window start and a shift amount. The request is presented with a one-cycle `start` strobe. One cycle later the block presents the effective address, the new pointer value and a write-back enable, qualified by `valid`.

Eight modes are supported. Two compute a plain address: base plus offset, and shifted index plus constant. One loads an absolute constant and also writes it into the pointer. Two are linear post-increment modes, stepping by the immediate or by the modifier. One is a bit-reversed post-increment for FFT-style access. Two are circular post-increment modes. Both keep the pointer inside a window that begins at the start register and whose length is read from the modifier. One of them steps by the immediate. The other unpacks a signed step count from the modifier and scales it by the access size.

Top module: `dsp_agu`

## Requirements
- R1: While `rst` is high, at the next clock edge `valid`, `wb_en`, `eff_addr` and `new_ptr` become zero.
- R2: Outputs are registered. A request with `start` high at edge N appears at edge N+1 with `valid` high. When `start` is low at an edge, `valid` and `wb_en` are low after that edge.
- R3: Mode 0 (base plus offset): `eff_addr` = base + imm and `wb_en` = 0.
- R4: Mode 1 (index): `eff_addr` = (base << shift) + imm and `wb_en` = 0.
- R5: Mode 2 (absolute set): `eff_addr` = imm, `new_ptr` = imm and `wb_en` = 1.
- R6: Mode 3 (post-increment by immediate): `eff_addr` = base, `new_ptr` = base + imm and `wb_en` = 1.
- R7: Mode 4 (post-increment by modifier): `eff_addr` = base, `new_ptr` = base + modifier and `wb_en` = 1.
- R8: Mode 5 (bit-reversed): `eff_addr` keeps base bits 31:16 and reverses the order of base bits 15:0. `new_ptr` = base + modifier and `wb_en` = 1. With base 0x10000 and modifier 0x2000, four successive accesses go to 0x10000, 0x10004, 0x10002 and 0x10006.
- R9: Mode 6 (circular by immediate): `eff_addr` = base. `new_ptr` = base + imm, wrapped into [cstart, cstart+len), where len = modifier bits 16:0. With len 2 and step 1 from cstart, successive pointers are cstart+1, +0, +1, +0.
- R10: Mode 7 (circular packed): the step is the signed count in modifier bits 23:17, multiplied by 2^size bytes (size code 0..3 means 1, 2, 4 or 8 bytes). The length is in modifier bits 16:0, and the wrap is as in R9. With len 4, count 1 and size code 1, successive pointers are cstart+2, +0, +2, +0.
- R11: Circular wrap: when base + step is at or above cstart + len, len is subtracted. When it is below cstart, len is added. A negative step below the window therefore re-enters from the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| size | input | 2 | Access size code, 2^size bytes |
| base | input | 32 | Current pointer or index operand |
| imm | input | 32 | Immediate offset, constant or signed step |
| modifier | input | 32 | Modifier word (step, or packed count and length) |
| cstart | input | 32 | Circular window start |
| shift | input | 5 | Index shift amount |
| valid | output | 1 | Outputs hold a result |
| eff_addr | output | 32 | Effective memory address |
| new_ptr | output | 32 | Pointer value to write back |
| wb_en | output | 1 | Pointer write-back enable |

## Verification
The window-range assertion assumes that a circular request starts with the pointer inside its window. It also assumes a nonzero length, a step smaller in magnitude than the length, and a window end that does not pass the top of the address space. Under those conditions a single add or subtract of the length always lands back inside the window. The random stimulus places the start well below the top of the address space and draws the pointer as start plus a value below the length. It draws the immediate step strictly inside (-len, len). For the packed mode it keeps the length above the largest scaled count, 64 × 8.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_BASE_OFF  = 3'd0,
    AM_INDEX     = 3'd1,
    AM_ABS_SET   = 3'd2,
    AM_POST_IMM  = 3'd3,
    AM_POST_MOD  = 3'd4,
    AM_BITREV    = 3'd5,
    AM_CIRC_IMM  = 3'd6,
    AM_CIRC_PACK = 3'd7
  } agu_mode_e;
endpackage

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW     = 32,
  parameter int BREV_W = 16
) (
  input  logic [AW-1:0] ptr_in,
  output logic [AW-1:0] addr_out
);
  // mirror the low field, keep everything above it
  for (genvar i = 0; i < BREV_W; i++) begin : g_rev
    assign addr_out[i] = ptr_in[BREV_W-1-i];
  end
  if (AW > BREV_W) begin : g_hi
    assign addr_out[AW-1:BREV_W] = ptr_in[AW-1:BREV_W];
  end
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int AW    = 32,
  parameter int LEN_W = 17
) (
  input  logic [AW-1:0]    ptr_in,
  input  logic [AW-1:0]    step,
  input  logic [AW-1:0]    win_lo,
  input  logic [LEN_W-1:0] win_len,
  output logic [AW-1:0]    ptr_out
);
  localparam int PADW = AW - LEN_W;
  logic [AW-1:0] len_ext, sum, win_hi;

  assign len_ext = {{PADW{1'b0}}, win_len};
  assign sum     = ptr_in + step;
  assign win_hi  = win_lo + len_ext;

  always_comb begin
    if (sum >= win_hi)      ptr_out = sum - len_ext;
    else if (sum < win_lo)  ptr_out = sum + len_ext;
    else                    ptr_out = sum;
  end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LEN_W   = 17,
  parameter int CNT_W   = 7,
  parameter int BREV_W  = 16,
  parameter int SHW     = 5,
  parameter int SZW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [SZW-1:0] size,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] modifier,
  input  logic [AW-1:0] cstart,
  input  logic [SHW-1:0] shift,
  output logic          valid,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] new_ptr,
  output logic          wb_en
);
  localparam int CNT_LSB = LEN_W;
  localparam int CNT_MSB = LEN_W + CNT_W - 1;

  agu_mode_e     mode_e;
  logic [AW-1:0] brev_addr, circ_ptr, circ_step, pack_step, cnt_ext;
  logic [AW-1:0] nx_addr, nx_ptr;
  logic          nx_wb;

  assign mode_e  = agu_mode_e'(mode);
  assign cnt_ext = {{(AW-CNT_W){modifier[CNT_MSB]}}, modifier[CNT_MSB:CNT_LSB]};
  assign pack_step = cnt_ext << size;
  assign circ_step = (mode_e == AM_CIRC_PACK) ? pack_step : imm;

  agu_bitrev #(.AW(AW), .BREV_W(BREV_W)) u_brev (
    .ptr_in  (base),
    .addr_out(brev_addr)
  );

  agu_circ #(.AW(AW), .LEN_W(LEN_W)) u_circ (
    .ptr_in (base),
    .step   (circ_step),
    .win_lo (cstart),
    .win_len(modifier[LEN_W-1:0]),
    .ptr_out(circ_ptr)
  );

  always_comb begin
    nx_addr = base;
    nx_ptr  = base;
    nx_wb   = 1'b1;
    case (mode_e)
      AM_BASE_OFF: begin
        nx_addr = base + imm;
        nx_wb   = 1'b0;
      end
      AM_INDEX: begin
        nx_addr = (base << shift) + imm;
        nx_wb   = 1'b0;
      end
      AM_ABS_SET: begin
        nx_addr = imm;
        nx_ptr  = imm;
      end
      AM_POST_IMM: nx_ptr = base + imm;
      AM_POST_MOD: nx_ptr = base + modifier;
      AM_BITREV: begin
        nx_addr = brev_addr;
        nx_ptr  = base + modifier;
      end
      AM_CIRC_IMM, AM_CIRC_PACK: nx_ptr = circ_ptr;
      default: nx_wb = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      wb_en    <= 1'b0;
      eff_addr <= '0;
      new_ptr  <= '0;
    end else if (start) begin
      valid    <= 1'b1;
      wb_en    <= nx_wb;
      eff_addr <= nx_addr;
      new_ptr  <= nx_ptr;
    end else begin
      valid    <= 1'b0;
      wb_en    <= 1'b0;
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW    = 32,
  parameter int LEN_W = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [2:0]    mode,
  input logic [AW-1:0] base,
  input logic [AW-1:0] imm,
  input logic [AW-1:0] modifier,
  input logic [AW-1:0] cstart,
  input logic          valid,
  input logic [AW-1:0] eff_addr,
  input logic [AW-1:0] new_ptr,
  input logic          wb_en
);
  logic [AW-1:0] len_w, neg_imm, win_end;
  logic          circ_ok;
  assign len_w   = {{(AW-LEN_W){1'b0}}, modifier[LEN_W-1:0]};
  assign neg_imm = -imm;
  assign win_end = cstart + len_w;
  // precondition for the range check: pointer inside, |step| < len
  assign circ_ok = (mode == 3'd6) && (len_w != '0) && (base >= cstart) &&
                   (base < win_end) && (win_end > cstart) &&
                   (imm[AW-1] ? (neg_imm < len_w) : (imm < len_w));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!valid && !wb_en && eff_addr == '0 && new_ptr == '0));

  assert_start_valid_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!valid && !wb_en));

  assert_base_off_R3: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 3'd0) |=> (!wb_en && eff_addr == $past(base + imm)));

  assert_abs_set_R5: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 3'd2) |=> (wb_en && new_ptr == eff_addr));

  assert_post_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (start && (mode == 3'd3 || mode == 3'd4 || mode >= 3'd6)) |=>
      (wb_en && eff_addr == $past(base)));

  assert_circ_window_R11: assert property (@(posedge clk) disable iff (rst)
    (start && circ_ok) |=>
      (new_ptr >= $past(cstart) && new_ptr < $past(win_end)));
endmodule

bind dsp_agu agu_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .base(base), .imm(imm),
  .modifier(modifier), .cstart(cstart), .valid(valid), .eff_addr(eff_addr),
  .new_ptr(new_ptr), .wb_en(wb_en)
);

// File: tb/sim_dsp_agu.sv
`timescale 1ns/1ps
module sim_dsp_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [31:0] base = '0, imm = '0, modifier = '0, cstart = '0;
  logic [4:0]  shift = '0;
  logic        valid, wb_en;
  logic [31:0] eff_addr, new_ptr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dsp_agu u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .size(size),
    .base(base), .imm(imm), .modifier(modifier), .cstart(cstart),
    .shift(shift), .valid(valid), .eff_addr(eff_addr), .new_ptr(new_ptr),
    .wb_en(wb_en)
  );

  function automatic logic [31:0] rev16(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [31:0] wrap(input logic [31:0] p, input logic [31:0] st,
                                       input logic [31:0] lo, input logic [31:0] len);
    logic [31:0] s;
    s = p + st;
    if (s >= lo + len) return s - len;
    if (s < lo) return s + len;
    return s;
  endfunction

  task automatic expect_op(output logic [31:0] ea, output logic [31:0] np,
                           output logic wb);
    logic [31:0] len, cnt;
    len = {15'd0, modifier[16:0]};
    cnt = {{25{modifier[23]}}, modifier[23:17]};
    ea = base; np = base; wb = 1'b1;
    case (mode)
      3'd0: begin ea = base + imm; wb = 1'b0; end
      3'd1: begin ea = (base << shift) + imm; wb = 1'b0; end
      3'd2: begin ea = imm; np = imm; end
      3'd3: np = base + imm;
      3'd4: np = base + modifier;
      3'd5: begin ea = rev16(base); np = base + modifier; end
      3'd6: np = wrap(base, imm, cstart, len);
      default: np = wrap(base, cnt * (32'd1 << size), cstart, len);
    endcase
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one request, check it one cycle later
  task automatic run_op(input string req);
    logic [31:0] ea, np;
    logic wb;
    expect_op(ea, np, wb);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req, "valid", {31'd0, valid}, 32'd1);
    chk(req, "eff_addr", eff_addr, ea);
    chk(req, "new_ptr", new_ptr, np);
    chk(req, "wb_en", {31'd0, wb_en}, {31'd0, wb});
  endtask

  task automatic set_op(input logic [2:0] m, input logic [1:0] sz,
                        input logic [31:0] b, input logic [31:0] i,
                        input logic [31:0] md, input logic [31:0] cs,
                        input logic [4:0] sh);
    mode = m; size = sz; base = b; imm = i; modifier = md; cstart = cs; shift = sh;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ptr, len, lo, st;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid", {31'd0, valid}, 32'd0);
    chk("R1", "eff_addr", eff_addr, 32'd0);
    chk("R1", "new_ptr", new_ptr, 32'd0);
    chk("R1", "wb_en", {31'd0, wb_en}, 32'd0);
    rst = 1'b0;

    // R3, R4, R5, R6, R7 directed
    set_op(3'd0, 2'd0, 32'h1000, 32'h24, 32'd0, 32'd0, 5'd0); run_op("R3");
    set_op(3'd1, 2'd0, 32'd3, 32'h8000, 32'd0, 32'd0, 5'd2); run_op("R4");
    set_op(3'd2, 2'd0, 32'h55, 32'hABCD0, 32'd0, 32'd0, 5'd0); run_op("R5");
    set_op(3'd3, 2'd1, 32'h200, 32'hFFFF_FFFE, 32'd0, 32'd0, 5'd0); run_op("R6");
    set_op(3'd4, 2'd0, 32'h200, 32'd0, 32'd12, 32'd0, 5'd0); run_op("R7");

    // R2: after an idle edge valid and wb_en drop
    @(negedge clk);
    chk("R2", "idle valid", {31'd0, valid}, 32'd0);
    chk("R2", "idle wb_en", {31'd0, wb_en}, 32'd0);

    // R8: bit-reversed walk
    ptr = 32'h10000;
    for (int k = 0; k < 4; k++) begin
      set_op(3'd5, 2'd0, ptr, 32'd0, 32'h2000, 32'd0, 5'd0);
      run_op("R8");
      ptr = new_ptr;
    end
    chk("R8", "last addr", eff_addr, 32'h10006);

    // R9: len 2 step 1 -> 1,0,1,0
    ptr = 32'h4000;
    for (int k = 0; k < 4; k++) begin
      set_op(3'd6, 2'd0, ptr, 32'd1, 32'd2, 32'h4000, 5'd0);
      run_op("R9");
      chk("R9", "seq", new_ptr, 32'h4000 + ((k % 2 == 0) ? 32'd1 : 32'd0));
      ptr = new_ptr;
    end

    // R10: len 4, count 1, half-word -> 2,0,2,0
    ptr = 32'h4000;
    for (int k = 0; k < 4; k++) begin
      set_op(3'd7, 2'd1, ptr, 32'd0, (32'd1 << 17) | 32'd4, 32'h4000, 5'd0);
      run_op("R10");
      chk("R10", "seq", new_ptr, 32'h4000 + ((k % 2 == 0) ? 32'd2 : 32'd0));
      ptr = new_ptr;
    end

    // R11: negative step below window re-enters from top
    set_op(3'd6, 2'd0, 32'd101, -32'sd3, 32'd10, 32'd100, 5'd0); run_op("R11");
    chk("R11", "neg wrap", new_ptr, 32'd108);
    set_op(3'd7, 2'd2, 32'd100, 32'd0, ({25'd0, 7'h7F} << 17) | 32'd10, 32'd100, 5'd0);
    run_op("R11");
    chk("R11", "packed neg wrap", new_ptr, 32'd106);

    // random mix over all modes
    for (int n = 0; n < 400; n++) begin
      mode  = 3'($urandom_range(0, 7));
      size  = 2'($urandom_range(0, 3));
      shift = 5'($urandom_range(0, 31));
      base  = $urandom; imm = $urandom; modifier = $urandom; cstart = $urandom;
      if (mode >= 3'd6) begin
        lo  = $urandom_range(0, 32'h4000_0000);
        len = $urandom_range(513, 131071);
        st  = $urandom_range(0, len - 1);
        cstart = lo;
        base = lo + $urandom_range(0, len - 1);
        imm  = ($urandom_range(0, 1) != 0) ? st : -st;
        modifier = ({25'd0, 7'($urandom)} << 17) | len;
      end
      case (mode)
        3'd0: run_op("R3");
        3'd1: run_op("R4");
        3'd2: run_op("R5");
        3'd3: run_op("R6");
        3'd4: run_op("R7");
        3'd5: run_op("R8");
        3'd6: run_op("R9");
        default: run_op("R10");
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule